// File: doc/BRIEF.md
# Chained Descriptor Ring Walker

This block walks a ring of four-word DMA descriptors for one direction of a network controller. Software loads a ring base address and raises the run input. The walker then reads the descriptor at its current address through a simple request/acknowledge memory port. If the controller owns that descriptor, the walker hands the buffer address, byte count and last-segment flag to a data-mover stub. When the mover reports completion with a status value, the walker writes that status back into word 0 with ownership cleared. It then follows the pointer held in word 3 to the next descriptor.

The ring is closed by chaining and not by a fixed stride, so descriptors may sit anywhere in memory. A descriptor still owned by the host puts the walker into a suspended state. It stays there, with no memory traffic, until a poll strobe makes it re-read the same descriptor. Dropping run halts the walker at a descriptor boundary, and a state output lets software confirm the halt before it reprograms the ring.

Descriptor layout: word 0 (offset 0) bit 31 is ownership, 1 meaning the controller owns the descriptor. Word 1 (offset 4) holds the buffer byte count in bits [SZW-1:0] and the last-segment flag in bit 30. Word 2 (offset 8) is the buffer address. Word 3 (offset 12) is the address of the next descriptor.

Top module: `desc_ring_walker`

## Requirements
- R1: After synchronous reset, eng_state is 0 (stopped), mem_req is 0 and mv_valid is 0, and they stay so while stopped.
- R2: When run rises while stopped, the walker reads the descriptor at the loaded base address, word 0 first. For an owned descriptor it goes on to read words 1, 2 and 3 at byte offsets 4, 8 and 12, in that order, and every access address is word aligned.
- R3: A descriptor whose word 0 bit 31 is 0 causes no further read of that descriptor, no write and no handoff. The walker enters eng_state 3 (suspended).
- R4: For an owned descriptor, mv_valid presents word 2 on mv_buf_addr, word 1 bits [SZW-1:0] on mv_size and word 1 bit 30 on mv_last. These values are held steady until mv_done.
- R5: After mv_done, the walker performs exactly one write, to word 0 of that descriptor, with data {1'b0, mv_status}. Words 1 to 3 are not written.
- R6: After the write-back, the next fetch starts at the address read from word 3, so the last descriptor wraps back to the first.
- R7: While suspended there is no memory access. A one-cycle poll pulse makes the walker re-read word 0 at the same address and proceed by its ownership bit.
- R8: With run low, a suspended walker enters stopped on the next clock. A walker in the middle of an owned descriptor finishes that descriptor's write-back and then stops without fetching the next one. Starting again begins at the base register, not at the chained pointer.
- R9: eng_state encodes 0 stopped, 1 fetching a descriptor, 2 running (handoff or write-back), 3 suspended.
- R10: A memory request, once raised, keeps its address and direction unchanged until mem_ack.
- R11: A base_we write while the walker runs does not alter the walk in progress; the new base is used at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run (1) or halt (0) request |
| poll | input | 1 | Poll-demand strobe, resumes a suspended walker |
| base_we | input | 1 | Load strobe for the ring base register |
| base_addr | input | AW | Ring base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completion |
| mv_valid | output | 1 | Buffer handoff valid |
| mv_buf_addr | output | AW | Buffer address from word 2 |
| mv_size | output | SZW | Buffer byte count from word 1 |
| mv_last | output | 1 | Last-segment flag from word 1 bit 30 |
| mv_done | input | 1 | Mover finished the buffer |
| mv_status | input | 31 | Status to write back into word 0 |
| eng_state | output | 2 | Engine state, encoded as in R9 |

## Verification
On every cycle the assertions check the port-level rules: requests stay steady until acknowledged, addresses are aligned, and write-backs always carry a cleared ownership bit. They also check that the handoff is held until done, that the stopped and suspended states are silent, and that a suspended walker without run stops on the next clock. What only the bench's scenarios can show is the content of the walk. That covers the order of word reads, the values handed off, the exact write-back data and its address, and the chained wrap from the last descriptor to the first. It also covers the poll re-fetch of the same descriptor, finishing the current descriptor before halting, and the restart at a base that was rewritten mid-walk.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

    localparam int DESC_WORDS = 4;
    localparam int IDXW       = $clog2(DESC_WORDS);
    localparam int OWN_BIT    = 31;
    localparam int LAST_BIT   = 30;
    localparam int STATUS_W   = 31;

    typedef enum logic [1:0] {
        ENG_STOPPED   = 2'd0,
        ENG_FETCHING  = 2'd1,
        ENG_RUNNING   = 2'd2,
        ENG_SUSPENDED = 2'd3
    } eng_state_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_HAND,
        PH_WB,
        PH_SUSP
    } phase_e;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] buf1;
        logic [31:0] link;
    } desc_words_t;

    function automatic eng_state_e phase_to_state(phase_e p);
        case (p)
            PH_READ:          return ENG_FETCHING;
            PH_HAND, PH_WB:   return ENG_RUNNING;
            PH_SUSP:          return ENG_SUSPENDED;
            default:          return ENG_STOPPED;
        endcase
    endfunction

endpackage

// File: rtl/walker_seq.sv
module walker_seq
    import ring_walk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            poll,
    input  logic            mem_ack,
    input  logic            own_flag,
    input  logic            mv_done,
    output phase_e          phase,
    output logic [IDXW-1:0] widx,
    output logic            ld_base,
    output logic            ld_next,
    output logic            cap_en,
    output logic            st_en
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 1);

    assign ld_base = (phase == PH_IDLE) && run;
    assign ld_next = (phase == PH_WB) && mem_ack;
    assign cap_en  = (phase == PH_READ) && mem_ack;
    assign st_en   = (phase == PH_HAND) && mv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            widx  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (run) begin
                        phase <= PH_READ;
                        widx  <= '0;
                    end
                end
                PH_READ: begin
                    if (mem_ack) begin
                        if (widx == '0 && !own_flag) begin
                            phase <= run ? PH_SUSP : PH_IDLE;
                            widx  <= '0;
                        end else if (widx == LAST_IDX) begin
                            phase <= PH_HAND;
                            widx  <= '0;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                PH_HAND: begin
                    if (mv_done) phase <= PH_WB;
                end
                PH_WB: begin
                    if (mem_ack) begin
                        phase <= run ? PH_READ : PH_IDLE;
                        widx  <= '0;
                    end
                end
                PH_SUSP: begin
                    if (!run) begin
                        phase <= PH_IDLE;
                    end else if (poll) begin
                        phase <= PH_READ;
                        widx  <= '0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/walker_ptr.sv
module walker_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic [AW-1:0] base_in,
    input  logic          ld_base,
    input  logic          ld_next,
    input  logic [AW-1:0] next_in,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur    <= '0;
        end else begin
            if (base_we) base_q <= base_in;
            if (ld_base)      cur <= base_q;
            else if (ld_next) cur <= next_in;
        end
    end

endmodule

// File: rtl/walker_capture.sv
module walker_capture
    import ring_walk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_en,
    input  logic [IDXW-1:0]     widx,
    input  logic [31:0]         rdata,
    input  logic                st_en,
    input  logic [STATUS_W-1:0] status_in,
    output logic [AW-1:0]       buf_addr,
    output logic [AW-1:0]       next_addr,
    output logic [SZW-1:0]      size,
    output logic                last,
    output logic [STATUS_W-1:0] status
);

    desc_words_t words;

    always_ff @(posedge clk) begin
        if (rst) begin
            words  <= '0;
            status <= '0;
        end else begin
            if (cap_en) begin
                case (widx)
                    IDXW'(1): words.ctrl <= rdata;
                    IDXW'(2): words.buf1 <= rdata;
                    IDXW'(3): words.link <= rdata;
                    default:  ;
                endcase
            end
            if (st_en) status <= status_in;
        end
    end

    assign buf_addr  = words.buf1[AW-1:0];
    assign next_addr = words.link[AW-1:0];
    assign size      = words.ctrl[SZW-1:0];
    assign last      = words.ctrl[LAST_BIT];

    logic unused_word_bits;
    assign unused_word_bits = ^{words.ctrl, words.buf1, words.link};

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
    import ring_walk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                poll,
    input  logic                base_we,
    input  logic [AW-1:0]       base_addr,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic [31:0]         mem_rdata,
    input  logic                mem_ack,
    output logic                mv_valid,
    output logic [AW-1:0]       mv_buf_addr,
    output logic [SZW-1:0]      mv_size,
    output logic                mv_last,
    input  logic                mv_done,
    input  logic [STATUS_W-1:0] mv_status,
    output logic [1:0]          eng_state
);

    phase_e                phase;
    logic [IDXW-1:0]       widx;
    logic                  ld_base, ld_next, cap_en, st_en;
    logic [AW-1:0]         cur, next_addr;
    logic [STATUS_W-1:0]   status_q;

    walker_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .poll     (poll),
        .mem_ack  (mem_ack),
        .own_flag (mem_rdata[OWN_BIT]),
        .mv_done  (mv_done),
        .phase    (phase),
        .widx     (widx),
        .ld_base  (ld_base),
        .ld_next  (ld_next),
        .cap_en   (cap_en),
        .st_en    (st_en)
    );

    walker_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .base_we (base_we),
        .base_in (base_addr),
        .ld_base (ld_base),
        .ld_next (ld_next),
        .next_in (next_addr),
        .cur     (cur)
    );

    walker_capture #(.AW(AW), .SZW(SZW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .widx      (widx),
        .rdata     (mem_rdata),
        .st_en     (st_en),
        .status_in (mv_status),
        .buf_addr  (mv_buf_addr),
        .next_addr (next_addr),
        .size      (mv_size),
        .last      (mv_last),
        .status    (status_q)
    );

    assign mem_req   = (phase == PH_READ) || (phase == PH_WB);
    assign mem_we    = (phase == PH_WB);
    assign mem_addr  = (phase == PH_READ) ? cur + AW'({widx, 2'b00}) : cur;
    assign mem_wdata = {1'b0, status_q};
    assign mv_valid  = (phase == PH_HAND);
    assign eng_state = phase_to_state(phase);

endmodule

// File: rtl/walker_checker.sv
module walker_checker #(
    parameter int AW  = 32,
    parameter int SZW = 11
) (
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic [31:0]    mem_wdata,
    input logic           mem_ack,
    input logic           mv_valid,
    input logic [AW-1:0]  mv_buf_addr,
    input logic [SZW-1:0] mv_size,
    input logic           mv_done,
    input logic [1:0]     eng_state
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_wb_own_clear_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[31]);

    assert_hand_hold_R4: assert property (@(posedge clk) disable iff (rst)
        mv_valid && !mv_done |=> mv_valid && $stable(mv_buf_addr) && $stable(mv_size));

    assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        eng_state == 2'd0 |-> !mem_req && !mv_valid);

    assert_susp_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        eng_state == 2'd3 |-> !mem_req && !mv_valid);

    assert_susp_halt_R8: assert property (@(posedge clk) disable iff (rst)
        eng_state == 2'd3 && !run |=> eng_state == 2'd0);

    assert_hand_state_R9: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> eng_state == 2'd2);

endmodule

bind desc_ring_walker walker_checker #(.AW(AW), .SZW(SZW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mv_valid    (mv_valid),
    .mv_buf_addr (mv_buf_addr),
    .mv_size     (mv_size),
    .mv_done     (mv_done),
    .eng_state   (eng_state)
);

// File: tb/sim_desc_ring_walker.sv
module sim_desc_ring_walker;

    localparam int AW  = 32;
    localparam int SZW = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, run, poll, base_we;
    logic [AW-1:0]  base_addr;
    logic           mem_req, mem_we, mem_ack;
    logic [AW-1:0]  mem_addr;
    logic [31:0]    mem_wdata, mem_rdata;
    logic           mv_valid, mv_last, mv_done;
    logic [AW-1:0]  mv_buf_addr;
    logic [SZW-1:0] mv_size;
    logic [30:0]    mv_status;
    logic [1:0]     eng_state;

    desc_ring_walker #(.AW(AW), .SZW(SZW)) u0 (
        .clk(clk), .rst(rst), .run(run), .poll(poll),
        .base_we(base_we), .base_addr(base_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mv_valid(mv_valid), .mv_buf_addr(mv_buf_addr), .mv_size(mv_size),
        .mv_last(mv_last), .mv_done(mv_done), .mv_status(mv_status),
        .eng_state(eng_state)
    );

    // descriptor table: {own, last, size[10:0], buffer[15:0]}
    localparam logic [28:0] DESC_TAB [4] = '{
        {1'b1, 1'b0, 11'd64,   16'h1000},
        {1'b1, 1'b1, 11'd1500, 16'h2200},
        {1'b1, 1'b1, 11'd7,    16'h3344},
        {1'b0, 1'b0, 11'd2047, 16'h4ff0}
    };
    localparam logic [31:0] RING_AT [4] = '{32'h080, 32'h1C0, 32'h040, 32'h140};

    // memory model and poke port
    logic [31:0] mem [128];
    logic        poke_en = 1'b0;
    logic [31:0] poke_a = '0, poke_d = '0;
    logic [31:0] lg_addr [64];
    logic        lg_we   [64];
    int          lg = 0;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        if (poke_en) mem[poke_a[8:2]] <= poke_d;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[8:2]];
            if (lg < 64) begin
                lg_addr[lg] <= mem_addr;
                lg_we[lg]   <= mem_we;
                lg <= lg + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // data mover stub
    logic [31:0]    hand_buf  [8];
    logic [SZW-1:0] hand_size [8];
    logic           hand_last [8];
    int             hn = 0;
    int             dly = 0;

    initial begin
        mv_done   = 1'b0;
        mv_status = '0;
    end

    always @(posedge clk) begin
        if (mv_valid && !mv_done) begin
            dly <= dly + 1;
            if (dly == 2) begin
                mv_done   <= 1'b1;
                mv_status <= {4'h5, mv_buf_addr[15:0], mv_size};
                if (hn < 8) begin
                    hand_buf[hn]  <= mv_buf_addr;
                    hand_size[hn] <= mv_size;
                    hand_last[hn] <= mv_last;
                end
                hn <= hn + 1;
            end
        end else begin
            mv_done <= 1'b0;
            dly     <= 0;
        end
    end

    int nchk = 0, nfail = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        poke_a  = a;
        poke_d  = d;
        poke_en = 1'b1;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_state(input logic [1:0] s, input int lim, input string tag);
        int n = 0;
        while (eng_state !== s && n < lim) begin
            @(negedge clk);
            n++;
        end
        chk(eng_state === s, tag, 32'(eng_state), 32'(s));
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; run = 1'b0; poll = 1'b0; base_we = 1'b0; base_addr = '0;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(eng_state == 2'd0 && !mem_req && !mv_valid, "R1 reset state",
            {eng_state, mem_req, mv_valid}, 32'h0);
        rst = 1'b0;

        // build the chained ring
        for (int i = 0; i < 4; i++) begin
            poke(RING_AT[i],      {DESC_TAB[i][28], 31'h0});
            poke(RING_AT[i] + 4,  {1'b0, DESC_TAB[i][27], 19'h0, DESC_TAB[i][26:16]});
            poke(RING_AT[i] + 8,  {16'h0, DESC_TAB[i][15:0]});
            poke(RING_AT[i] + 12, RING_AT[(i + 1) % 4]);
        end
        @(negedge clk);
        chk(eng_state == 2'd0 && !mem_req, "R1 idle while stopped", 32'(eng_state), 32'h0);

        base_addr = RING_AT[0]; base_we = 1'b1;
        @(negedge clk);
        base_we = 1'b0; run = 1'b1;
        @(negedge clk);
        chk(eng_state == 2'd1, "R9 fetching after start", 32'(eng_state), 32'h1);
        wait_state(2'd3, 400, "R3 suspends on host-owned descriptor");

        // table walk: per-descriptor results
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w0_exp;
            w0_exp = DESC_TAB[i][28] ? {1'b0, 4'h5, DESC_TAB[i][15:0], DESC_TAB[i][26:16]} : 32'h0;
            chk(mem[RING_AT[i][8:2]] == w0_exp, "R5 word0 write-back", mem[RING_AT[i][8:2]], w0_exp);
            chk(mem[RING_AT[i][8:2] + 3] == RING_AT[(i + 1) % 4], "R5 link word untouched",
                mem[RING_AT[i][8:2] + 3], RING_AT[(i + 1) % 4]);
            if (DESC_TAB[i][28]) begin
                chk(hand_buf[i] == {16'h0, DESC_TAB[i][15:0]}, "R4 handoff buffer",
                    hand_buf[i], {16'h0, DESC_TAB[i][15:0]});
                chk(hand_size[i] == DESC_TAB[i][26:16] && hand_last[i] == DESC_TAB[i][27],
                    "R4 handoff size/last", {hand_last[i], 20'h0, hand_size[i]},
                    {DESC_TAB[i][27], 20'h0, DESC_TAB[i][26:16]});
                for (int w = 0; w < 4; w++)
                    chk(lg_addr[i * 5 + w] == RING_AT[i] + 32'(w * 4) && !lg_we[i * 5 + w],
                        "R2 word read order", lg_addr[i * 5 + w], RING_AT[i] + 32'(w * 4));
                chk(lg_we[i * 5 + 4] && lg_addr[i * 5 + 4] == RING_AT[i], "R5 single write to word0",
                    lg_addr[i * 5 + 4], RING_AT[i]);
            end
        end
        chk(lg_addr[5] == RING_AT[1], "R6 follows chained pointer", lg_addr[5], RING_AT[1]);
        chk(lg == 16 && lg_addr[15] == RING_AT[3] && !lg_we[15], "R3 only word0 read when host-owned",
            32'(lg), 32'd16);
        chk(hn == 3, "R3 no handoff for host-owned", 32'(hn), 32'd3);

        // R7: quiet while suspended, poll refetches the same descriptor
        repeat (20) @(negedge clk);
        chk(lg == 16 && eng_state == 2'd3, "R7 no traffic while suspended", 32'(lg), 32'd16);
        poke(RING_AT[3], 32'h8000_0000);
        repeat (5) @(negedge clk);
        chk(lg == 16, "R7 ownership change alone does not resume", 32'(lg), 32'd16);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        wait_state(2'd3, 400, "R7 suspends again after poll walk");
        chk(lg_addr[16] == RING_AT[3] && !lg_we[16], "R7 poll refetches same address",
            lg_addr[16], RING_AT[3]);
        chk(hn == 4 && hand_buf[3] == 32'h4ff0, "R7 polled descriptor handed off", hand_buf[3], 32'h4ff0);
        chk(lg == 22 && lg_addr[21] == RING_AT[0], "R6 ring wraps to first descriptor",
            lg_addr[21], RING_AT[0]);

        // R8: halt from suspended
        run = 1'b0;
        @(negedge clk);
        chk(eng_state == 2'd0, "R8 suspended to stopped", 32'(eng_state), 32'h0);

        // R8/R11: halt mid-descriptor, base rewrite while running
        poke(RING_AT[0], 32'h8000_0000);
        poke(RING_AT[1], 32'h8000_0000);
        run = 1'b1;
        begin
            int n = 0;
            while (!mv_valid && n < 200) begin
                @(negedge clk);
                n++;
            end
        end
        chk(mv_valid == 1'b1, "R2 restart reaches handoff", 32'(mv_valid), 32'h1);
        base_addr = RING_AT[2]; base_we = 1'b1; run = 1'b0;
        @(negedge clk);
        base_we = 1'b0;
        wait_state(2'd0, 400, "R8 stops after current descriptor");
        chk(hn == 5 && hand_buf[4] == 32'h1000, "R11 walk unaffected by base write",
            hand_buf[4], 32'h1000);
        chk(lg == 27 && lg_we[26] && lg_addr[26] == RING_AT[0], "R8 write-back completes before stop",
            lg_addr[26], RING_AT[0]);
        chk(mem[RING_AT[1][8:2]][31] == 1'b1, "R8 next descriptor not taken",
            mem[RING_AT[1][8:2]], 32'h8000_0000);

        run = 1'b1;
        wait_state(2'd3, 400, "R8 restart suspends at new base");
        chk(lg == 28 && lg_addr[27] == RING_AT[2], "R11 restart uses rewritten base",
            lg_addr[27], RING_AT[2]);
        run = 1'b0;
        @(negedge clk);
        chk(eng_state == 2'd0, "R9 stopped encoding", 32'(eng_state), 32'h0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule